// File: doc/BRIEF.md
# Stepped Brightness Fade Controller

This block moves a 5-bit brightness code toward a target code that was just written. With fading on, the code changes by one count per step interval, so a display backlight brightens or dims in even increments instead of jumping. A 2-bit rate select sets the step interval as a whole number of millisecond ticks. A slow external strobe supplies the ticks, and the block itself uses one fast clock.

A write is taken only while the block is idle. A write that needs a fade raises `busy`. While busy, further writes are dropped. Clearing the fade enable ends a fade early by jumping to the target. Changing the rate during a fade restarts the interval count under the new rate. With fading off, a written code reaches the output on the next clock.

Top module: `fade_ctrl`

## Requirements
- R1: After reset, `level` is 0 and `busy` is 0.
- R2: The step interval is `(4 - rate_sel) * BASE_TICKS` ticks of `ms_tick`. The encodings are 00 for 4 units, 01 for 3 units, 10 for 2 units and 11 for 1 unit. With the default `BASE_TICKS` of 8, these are 32, 24, 16 and 8 ms per step.
- R3: While a fade runs with `ms_tick` high on every clock, `level` moves by exactly one count toward the target every interval. It goes upward or downward as needed and never skips a value.
- R4: A fade takes as many steps as the distance between the old code and the new code, so its duration is that distance times the interval. With the default parameters, a full-range fade at the slowest rate lasts about one second.
- R5: A write while `busy` is high is ignored. The fade already in progress ends on its original target at its original time.
- R6: If `fade_en` is low on a clock edge while `busy` is high, `level` equals the target and `busy` is low after that edge.
- R7: A write with `fade_en` low puts `wr_code` on `level` after the next edge, and `busy` stays low.
- R8: A change of `rate_sel` during a fade takes effect at once. The edge that sees the change clears the interval count, and the next step comes one full new interval after that edge.
- R9: `busy` rises on the edge that accepts a fading write. It falls on the edge at which `level` reaches the target. A fading write whose code equals the present `level` never raises `busy`.
- R10: Only `ms_tick` advances a fade. While `ms_tick` is held low, `level` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-clock timebase pulse, nominally once per millisecond |
| wr_en | input | 1 | Write strobe for a new target code |
| wr_code | input | 5 | Target brightness code |
| fade_en | input | 1 | 1 = fade toward targets, 0 = apply targets at once |
| rate_sel | input | 2 | Step interval select (see R2) |
| level | output | 5 | Present brightness code |
| busy | output | 1 | High while a fade is in progress |

## Verification
The bench builds the block with `BASE_TICKS` set to 2, so the four rates give intervals of 8, 6, 4 and 2 ticks. With `ms_tick` held high, every interval is a handful of clocks. This makes it possible to check each rate cycle by cycle, including full-range fades in both directions, a rate change in the middle of an interval, and a cancel that lands between two steps. One phase holds the tick low to show that the timebase gates all motion.

// File: rtl/fade_pkg.sv
package fade_pkg;
    // Width of the rate select field.
    localparam int RATE_W = 2;

    // Number of base units per step for a given rate select: larger code, shorter interval.
    function automatic int unsigned rate_units(input logic [RATE_W-1:0] sel);
        return (2 ** RATE_W) - int'(sel);
    endfunction
endpackage

// File: rtl/fade_rate_decode.sv
module fade_rate_decode #(
    parameter int RATE_W     = 2,
    parameter int BASE_TICKS = 8,
    parameter int CNT_W      = 6
) (
    input  logic [RATE_W-1:0] rate_sel,
    output logic [CNT_W-1:0]  limit
);
    // Interval length in ticks for the selected rate.
    always_comb begin
        limit = CNT_W'(fade_pkg::rate_units(rate_sel) * BASE_TICKS);
    end
endmodule

// File: rtl/fade_interval_timer.sv
module fade_interval_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             step_due
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    always_comb begin
        at_end   = (cnt_q == (limit - 1'b1));
        step_due = run && tick && !restart && at_end;
        cnt_d    = cnt_q;
        if (!run || restart) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = at_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: a rate change clears the count.
    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> (cnt_q == '0));
    // R2: the count stays inside the selected interval.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |-> (cnt_q < limit));
    // R10: without a tick the count holds.
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/fade_stepper.sv
module fade_stepper #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              fade_en,
    input  logic              step_due,
    output logic [CODE_W-1:0] level,
    output logic              busy
);
    typedef struct packed {
        logic [CODE_W-1:0] level;
        logic [CODE_W-1:0] target;
        logic              busy;
    } step_state_t;

    step_state_t st_d, st_q;
    logic [CODE_W-1:0] moved;

    always_comb begin
        moved = (st_q.level < st_q.target) ? st_q.level + 1'b1 : st_q.level - 1'b1;
        st_d  = st_q;
        if (st_q.busy) begin
            if (!fade_en) begin
                st_d.level = st_q.target;
                st_d.busy  = 1'b0;
            end else if (step_due) begin
                st_d.level = moved;
                st_d.busy  = (moved != st_q.target);
            end
        end else if (wr_en) begin
            if (!fade_en) begin
                st_d.level  = wr_code;
                st_d.target = wr_code;
            end else if (wr_code != st_q.level) begin
                st_d.target = wr_code;
                st_d.busy   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign busy  = st_q.busy;

    // R3: a step moves the code one count toward the target.
    p_one_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && fade_en && step_due) |=>
            ((($past(st_q.level) < $past(st_q.target)) && (st_q.level == CODE_W'($past(st_q.level) + 1'b1))) ||
             (($past(st_q.level) > $past(st_q.target)) && (st_q.level == CODE_W'($past(st_q.level) - 1'b1)))));
    // R5: the target is frozen during a fade.
    p_target_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && fade_en) |=> $stable(st_q.target));
    // R6: cancel lands on the target.
    p_cancel_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fade_en) |=> (!st_q.busy && st_q.level == st_q.target));
    // R7: direct write applies immediately.
    p_direct_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && wr_en && !fade_en) |=> (!st_q.busy && st_q.level == $past(wr_code)));
    // R9: busy only while level differs from the target.
    p_busy_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.level != st_q.target));
endmodule

// File: rtl/fade_ctrl.sv
module fade_ctrl #(
    parameter int CODE_W     = 5,
    parameter int BASE_TICKS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ms_tick,
    input  logic                        wr_en,
    input  logic [CODE_W-1:0]           wr_code,
    input  logic                        fade_en,
    input  logic [fade_pkg::RATE_W-1:0] rate_sel,
    output logic [CODE_W-1:0]           level,
    output logic                        busy
);
    localparam int RATE_W    = fade_pkg::RATE_W;
    localparam int MAX_TICKS = (2 ** RATE_W) * BASE_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [RATE_W-1:0] rate_d, rate_q;
    logic [CNT_W-1:0]  limit;
    logic              rate_moved;
    logic              step_due;

    always_comb begin
        rate_d     = rate_sel;
        rate_moved = (rate_sel != rate_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_d;
    end

    fade_rate_decode #(
        .RATE_W    (RATE_W),
        .BASE_TICKS(BASE_TICKS),
        .CNT_W     (CNT_W)
    ) u_rate (
        .rate_sel(rate_sel),
        .limit   (limit)
    );

    fade_interval_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (rate_moved),
        .tick    (ms_tick),
        .limit   (limit),
        .step_due(step_due)
    );

    fade_stepper #(
        .CODE_W(CODE_W)
    ) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .fade_en (fade_en),
        .step_due(step_due),
        .level   (level),
        .busy    (busy)
    );

    // R10: no tick, no motion while fading.
    p_tick_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fade_en && !ms_tick) |=> $stable(level));
    // R8: the edge seeing a rate change never steps.
    p_rate_edge_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fade_en && rate_moved) |=> $stable(level));
endmodule

// File: tb/fade_ctrl_tb.sv
module fade_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 5;
    localparam int BASE_TICKS = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ms_tick = 1'b1;
    logic              wr_en = 1'b0;
    logic [CODE_W-1:0] wr_code = '0;
    logic              fade_en = 1'b1;
    logic [1:0]        rate_sel = 2'b00;
    logic [CODE_W-1:0] level;
    logic              busy;

    fade_ctrl #(.CODE_W(CODE_W), .BASE_TICKS(BASE_TICKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en),
        .wr_code(wr_code), .fade_en(fade_en), .rate_sel(rate_sel),
        .level(level), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int                n_vec = 0;
    int                n_bad = 0;
    int                cur = 0;
    bit                finished = 1'b0;
    logic [CODE_W-1:0] exp_q[$];
    logic [CODE_W-1:0] prev_level = '0;
    logic [CODE_W-1:0] exp_item;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int interval(input int r);
        return (4 - r) * BASE_TICKS;
    endfunction

    // Monitor: every change of level must match the next scoreboard item.
    always @(negedge clk) begin
        if (rst_n && !finished && level !== prev_level) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected level change", int'(level), int'(prev_level));
            end else begin
                exp_item = exp_q.pop_front();
                check(level === exp_item, "R3 scoreboard order", int'(level), int'(exp_item));
            end
            prev_level = level;
        end
    end

    task automatic write(input int code, input bit fe);
        wr_code = CODE_W'(code);
        fade_en = fe;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy === 1'b1 && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    // Driver: push the expected codes, write, and check each step at its edge.
    task automatic fade_run(input int tgt, input int rate, input string req);
        int l;
        int dir;
        int steps;
        l     = interval(rate);
        dir   = (tgt > cur) ? 1 : -1;
        steps = (tgt > cur) ? tgt - cur : cur - tgt;
        rate_sel = rate[1:0];
        for (int v = cur + dir; v != tgt + dir; v += dir) exp_q.push_back(CODE_W'(v));
        write(tgt, 1'b1);
        check(busy === 1'b1, {req, " R9 busy after accept"}, int'(busy), 1);
        for (int k = 1; k <= steps; k++) begin
            repeat (l - 1) @(negedge clk);
            check(int'(level) == cur + (k - 1) * dir, {req, " R3 hold within interval"}, int'(level), cur + (k - 1) * dir);
            if (k == steps) check(busy === 1'b1, {req, " R4 busy until last step"}, int'(busy), 1);
            @(negedge clk);
            check(int'(level) == cur + k * dir, {req, " R2 step at interval end"}, int'(level), cur + k * dir);
        end
        check(busy === 1'b0, {req, " R9 busy falls with last step"}, int'(busy), 0);
        cur = tgt;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        check(level === '0, "R1 reset level", int'(level), 0);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: direct write
        exp_q.push_back(CODE_W'(12));
        write(12, 1'b0);
        check(int'(level) == 12, "R7 direct write level", int'(level), 12);
        check(busy === 1'b0, "R7 direct write busy", int'(busy), 0);
        cur = 12;
        fade_en = 1'b1;
        @(negedge clk);

        // R2/R3 all four rates, both directions
        fade_run(17, 3, "rate11 up");
        fade_run(13, 2, "rate10 down");
        fade_run(15, 1, "rate01 up");
        fade_run(14, 0, "rate00 down");

        // R9: equal code never raises busy
        write(14, 1'b1);
        check(busy === 1'b0, "R9 equal write busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(int'(level) == 14, "R9 equal write level", int'(level), 14);

        // R5: write during fade is dropped
        rate_sel = 2'b11;
        for (int v = 15; v <= 20; v++) exp_q.push_back(CODE_W'(v));
        write(20, 1'b1);
        @(negedge clk);
        write(3, 1'b1);
        wait_idle(cyc);
        check(int'(level) == 20, "R5 blocked write final level", int'(level), 20);
        check(cyc == 10, "R5 blocked write timing", cyc, 10);
        cur = 20;

        // R6: cancel mid-fade at rate 00 (8 ticks)
        rate_sel = 2'b00;
        exp_q.push_back(CODE_W'(19));
        exp_q.push_back(CODE_W'(4));
        write(4, 1'b1);
        repeat (10) @(negedge clk);
        check(int'(level) == 19, "R6 one step before cancel", int'(level), 19);
        fade_en = 1'b0;
        @(negedge clk);
        check(int'(level) == 4, "R6 cancel jumps to target", int'(level), 4);
        check(busy === 1'b0, "R6 cancel clears busy", int'(busy), 0);
        fade_en = 1'b1;
        cur = 4;
        @(negedge clk);

        // R8: rate change mid-interval restarts the count
        rate_sel = 2'b00;
        for (int v = 5; v <= 10; v++) exp_q.push_back(CODE_W'(v));
        write(10, 1'b1);
        repeat (8) @(negedge clk);
        check(int'(level) == 5, "R8 first step at old rate", int'(level), 5);
        repeat (3) @(negedge clk);
        rate_sel = 2'b11;
        @(negedge clk);
        check(int'(level) == 5, "R8 no step on change edge", int'(level), 5);
        @(negedge clk);
        check(int'(level) == 5, "R8 counting new interval", int'(level), 5);
        @(negedge clk);
        check(int'(level) == 6, "R8 step after new interval", int'(level), 6);
        wait_idle(cyc);
        check(int'(level) == 10 && cyc == 8, "R8 remaining steps at new rate", cyc, 8);
        cur = 10;

        // R10: no tick, no motion
        ms_tick = 1'b0;
        exp_q.push_back(CODE_W'(9));
        exp_q.push_back(CODE_W'(8));
        write(8, 1'b1);
        repeat (20) @(negedge clk);
        check(int'(level) == 10, "R10 level held without tick", int'(level), 10);
        check(busy === 1'b1, "R10 busy held without tick", int'(busy), 1);
        ms_tick = 1'b1;
        wait_idle(cyc);
        check(int'(level) == 8 && cyc == 4, "R10 resume after ticks", cyc, 4);
        cur = 8;

        // R4: full-range fades
        exp_q.push_back(CODE_W'(0));
        write(0, 1'b0);
        fade_en = 1'b1;
        cur = 0;
        @(negedge clk);
        fade_run(31, 0, "R4 full range up");
        fade_run(0, 3, "R4 full range down");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule